// File: doc/BRIEF.md
# Sparse Row Multiply Tree Front-End

This block is the multiply-and-reduce front end of a streaming sparse matrix times dense vector engine. Each cycle in which its input stream is not empty, it takes one beat of `LEAVES` matrix values and the `LEAVES` column indices that go with them. Every lane owns a private copy of the dense vector in on-chip memory. The lane looks up the vector element named by its column index and multiplies it with its matrix value. A pipelined binary adder tree then folds the lane products into one partial dot product per cycle. A valid flag and a free sideband tag travel beside the data, so that a downstream accumulator can match each partial sum to its row slot.

All arithmetic is signed two's-complement integer and full width, so results are exact and no floating-point cores are needed. The dense vector is loaded through a small write port while the block is idle. A three-state controller (IDLE, RUN, DRAIN) tracks the input stream. In IDLE the block is empty and accepts vector writes. A deasserted `in_empty` moves it to RUN, where a beat is taken on every cycle the stream has data. When the stream runs dry the block moves to DRAIN: reads stop, but the multipliers and the tree keep advancing, and every beat already taken leaves at its fixed cycle. The block returns to RUN on the next read, or falls back to IDLE once the pipeline is known to be empty.

Top module: `spmv_tree_frontend`

## Requirements
- R1: For each accepted beat, `out_sum` equals the exact signed sum over all lanes i of `value_i * vec[col_i]`. Lane i uses bits `[i*VAL_W +: VAL_W]` of `in_vals` and `[i*IDX_W +: IDX_W]` of `in_cols`. The sum is `2*VAL_W + log2(LEAVES)` bits wide, so it cannot overflow.
- R2: `in_rd` is high in exactly the cycles in which `in_empty` is low, and a beat is consumed in each such cycle.
- R3: A beat consumed in cycle c appears with `out_valid` high in cycle c + LAT, where LAT = 1 + MUL_LAT + log2(LEAVES). Beats come out in order, one per cycle, with no stall.
- R4: A lane whose value is zero (row padding) adds nothing to the sum, whatever its column index.
- R5: Each cycle without a read produces a bubble LAT cycles later: `out_valid` low and `out_sum` zero.
- R6: `out_tag` repeats the `in_tag` of the beat whose sum is on `out_sum`, and it is zero in bubble cycles.
- R7: A vector write (`vec_we` high) is applied to every lane copy only when the controller is in IDLE and `in_empty` is high; otherwise it is ignored. A write to an address at or above DEPTH is ignored. A later read returns the most recent accepted write.
- R8: A column index at or above DEPTH reads as zero, so that lane contributes nothing.
- R9: Reset puts the controller in IDLE with `out_valid` low, `out_sum` zero and `out_tag` zero. Transitions: IDLE to RUN on a read; RUN to DRAIN on a cycle without a read; DRAIN to RUN on a read; DRAIN to IDLE after LAT-1 DRAIN cycles in a row without a read. As a result, a write presented LAT cycles after the last read is ignored, and a write presented LAT+1 cycles after it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_empty | input | 1 | Input stream has no beat this cycle |
| in_rd | output | 1 | Beat is consumed this cycle |
| in_vals | input | LEAVES*VAL_W | Signed matrix values, one per lane |
| in_cols | input | LEAVES*IDX_W | Column indices, one per lane |
| in_tag | input | TAG_W | Sideband tag of the beat |
| vec_we | input | 1 | Dense vector write enable |
| vec_addr | input | IDX_W | Dense vector write address |
| vec_data | input | VAL_W | Dense vector write data, signed |
| out_valid | output | 1 | Partial sum is valid |
| out_sum | output | 2*VAL_W+log2(LEAVES) | Signed partial dot product |
| out_tag | output | TAG_W | Tag of the beat on `out_sum` |

## Verification
The bench builds the block with four lanes, 16-bit values, a 64-entry vector and a two-stage multiplier. These values give a five-cycle latency and a 34-bit sum. With such a small vector, random column indices often land past its end, and writes to addresses above 63 test whether the write address is truncated into range. Extreme 16-bit operands put the sum close to its top bit. The short latency keeps the DRAIN-to-IDLE edge close enough to test writes one cycle before and on the first cycle the block is idle.

// File: rtl/spmv_pkg.sv
package spmv_pkg;

    // Controller states of the front end.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } fe_state_t;

endpackage

// File: rtl/spmv_ctrl.sv
module spmv_ctrl
    import spmv_pkg::*;
#(
    parameter int LAT = 5
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_empty,
    output logic      rd,
    output logic      idle,
    output fe_state_t state
);
    localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(LAT - 2);

    fe_state_t     nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            ST_IDLE: begin
                if (!in_empty) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (in_empty) begin
                    nxt     = ST_DRAIN;
                    cnt_nxt = '0;
                end
            end
            ST_DRAIN: begin
                if (!in_empty)            nxt = ST_RUN;
                else if (cnt == CNT_LAST) nxt = ST_IDLE;
                else                      cnt_nxt = cnt + 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd   = !in_empty;
        idle = (state == ST_IDLE);
    end

    // RUN is only ever entered or held on a cycle that consumed a beat.
    assert_run_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> $past(rd));

    // DRAIN is only entered or held on a cycle with no read (R2, R9).
    assert_drain_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> !$past(rd));

endmodule

// File: rtl/spmv_leaf.sv
module spmv_leaf #(
    parameter int VAL_W   = 64,
    parameter int IDX_W   = 16,
    parameter int DEPTH   = 512,
    parameter int MUL_LAT = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_addr,
    input  logic [VAL_W-1:0]          wr_data,
    input  logic                      rd_en,
    input  logic [IDX_W-1:0]          col,
    input  logic [VAL_W-1:0]          val,
    output logic signed [2*VAL_W-1:0] prod
);
    localparam int PROD_W = 2 * VAL_W;
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W:0] DEPTH_V = (IDX_W + 1)'(DEPTH);

    logic [VAL_W-1:0] mem [DEPTH];

    logic wr_ok;
    logic rd_ok;
    assign wr_ok = wr_en && ({1'b0, wr_addr} < DEPTH_V);
    assign rd_ok = {1'b0, col} < DEPTH_V;

    // Private copy of the dense vector.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_addr[AW-1:0]] <= wr_data;
    end

    // Stage A: operand fetch; bubbles and out-of-range indices give zero.
    logic signed [VAL_W-1:0] val_q;
    logic signed [VAL_W-1:0] opnd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q  <= '0;
            opnd_q <= '0;
        end else if (rd_en) begin
            val_q  <= val;
            opnd_q <= rd_ok ? mem[col[AW-1:0]] : '0;
        end else begin
            val_q  <= '0;
            opnd_q <= '0;
        end
    end

    // Multiplier pipeline.
    logic signed [PROD_W-1:0] mp [MUL_LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MUL_LAT; i++) mp[i] <= '0;
        end else begin
            mp[0] <= val_q * opnd_q;
            for (int i = 1; i < MUL_LAT; i++) mp[i] <= mp[i-1];
        end
    end

    assign prod = mp[MUL_LAT-1];

endmodule

// File: rtl/spmv_tree.sv
module spmv_tree #(
    parameter int LEAVES = 4,
    parameter int IN_W   = 128
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [LEAVES*IN_W-1:0]                leaf_in,
    output logic signed [IN_W+$clog2(LEAVES)-1:0] sum
);
    localparam int LVL   = $clog2(LEAVES);
    localparam int SUM_W = IN_W + LVL;

    for (genvar l = 0; l <= LVL; l++) begin : g_lvl
        localparam int N = LEAVES >> l;
        logic signed [SUM_W-1:0] s [N];

        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < N; i++) begin : g_ext
                assign s[i] = {{LVL{leaf_in[i*IN_W+IN_W-1]}}, leaf_in[i*IN_W +: IN_W]};
            end
        end else begin : g_add
            for (genvar i = 0; i < N; i++) begin : g_node
                always_ff @(posedge clk) begin
                    if (!rst_n) s[i] <= '0;
                    else        s[i] <= g_lvl[l-1].s[2*i] + g_lvl[l-1].s[2*i+1];
                end
            end
        end
    end

    assign sum = g_lvl[LVL].s[0];

endmodule

// File: rtl/spmv_tree_frontend.sv
module spmv_tree_frontend
    import spmv_pkg::*;
#(
    parameter int LEAVES  = 4,
    parameter int VAL_W   = 64,
    parameter int IDX_W   = 16,
    parameter int DEPTH   = 512,
    parameter int MUL_LAT = 3,
    parameter int TAG_W   = 8
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     in_empty,
    output logic                                     in_rd,
    input  logic [LEAVES*VAL_W-1:0]                  in_vals,
    input  logic [LEAVES*IDX_W-1:0]                  in_cols,
    input  logic [TAG_W-1:0]                         in_tag,
    input  logic                                     vec_we,
    input  logic [IDX_W-1:0]                         vec_addr,
    input  logic [VAL_W-1:0]                         vec_data,
    output logic                                     out_valid,
    output logic signed [2*VAL_W+$clog2(LEAVES)-1:0] out_sum,
    output logic [TAG_W-1:0]                         out_tag
);
    localparam int LVL    = $clog2(LEAVES);
    localparam int PROD_W = 2 * VAL_W;
    localparam int LAT    = 1 + MUL_LAT + LVL;

    fe_state_t state;
    logic      rd;
    logic      idle;
    logic      load_en;

    spmv_ctrl #(.LAT(LAT)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_empty (in_empty),
        .rd       (rd),
        .idle     (idle),
        .state    (state)
    );

    assign in_rd   = rd;
    assign load_en = vec_we && idle && in_empty;

    logic [LEAVES*PROD_W-1:0] prods;

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        logic signed [PROD_W-1:0] p;
        spmv_leaf #(
            .VAL_W   (VAL_W),
            .IDX_W   (IDX_W),
            .DEPTH   (DEPTH),
            .MUL_LAT (MUL_LAT)
        ) u_leaf (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (load_en),
            .wr_addr (vec_addr),
            .wr_data (vec_data),
            .rd_en   (rd),
            .col     (in_cols[i*IDX_W +: IDX_W]),
            .val     (in_vals[i*VAL_W +: VAL_W]),
            .prod    (p)
        );
        assign prods[i*PROD_W +: PROD_W] = p;
    end

    spmv_tree #(.LEAVES(LEAVES), .IN_W(PROD_W)) u_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .leaf_in (prods),
        .sum     (out_sum)
    );

    // Valid and tag travel beside the data for exactly LAT cycles.
    logic [TAG_W:0] vt [LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) vt[i] <= '0;
        end else begin
            vt[0] <= rd ? {1'b1, in_tag} : '0;
            for (int i = 1; i < LAT; i++) vt[i] <= vt[i-1];
        end
    end

    assign out_valid = vt[LAT-1][TAG_W];
    assign out_tag   = vt[LAT-1][TAG_W-1:0];

    // The tree output of a bubble slot is zero.
    assert_bubble_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_sum == '0));

    // The tag is cleared in bubble slots.
    assert_tag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_tag == '0));

    // Once the controller is idle, nothing is left in flight.
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!out_valid && out_sum == '0));

    // A vector write is never applied while a beat is being read.
    assert_load_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> !in_rd);

endmodule

// File: tb/test_spmv_tree_frontend.sv
module test_spmv_tree_frontend;
    localparam int LEAVES  = 4;
    localparam int VAL_W   = 16;
    localparam int IDX_W   = 16;
    localparam int DEPTH   = 64;
    localparam int MUL_LAT = 2;
    localparam int TAG_W   = 8;
    localparam int LAT     = 1 + MUL_LAT + 2;
    localparam int SUM_W   = 2 * VAL_W + 2;
    localparam int NREC    = 4096;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                       rst_n;
    logic                       in_empty;
    logic                       in_rd;
    logic [LEAVES*VAL_W-1:0]    in_vals;
    logic [LEAVES*IDX_W-1:0]    in_cols;
    logic [TAG_W-1:0]           in_tag;
    logic                       vec_we;
    logic [IDX_W-1:0]           vec_addr;
    logic [VAL_W-1:0]           vec_data;
    logic                       out_valid;
    logic signed [SUM_W-1:0]    out_sum;
    logic [TAG_W-1:0]           out_tag;

    spmv_tree_frontend #(
        .LEAVES(LEAVES), .VAL_W(VAL_W), .IDX_W(IDX_W),
        .DEPTH(DEPTH), .MUL_LAT(MUL_LAT), .TAG_W(TAG_W)
    ) i_spmv_tree_frontend (
        .clk(clk), .rst_n(rst_n), .in_empty(in_empty), .in_rd(in_rd),
        .in_vals(in_vals), .in_cols(in_cols), .in_tag(in_tag),
        .vec_we(vec_we), .vec_addr(vec_addr), .vec_data(vec_data),
        .out_valid(out_valid), .out_sum(out_sum), .out_tag(out_tag)
    );

    int     n_chk  = 0;
    int     n_fail = 0;
    int     cyc    = 0;
    bit     done   = 0;
    longint shadow [DEPTH];
    bit     ev [NREC];
    longint es [NREC];
    logic [TAG_W-1:0] et [NREC];
    logic signed [VAL_W-1:0] bv [LEAVES];
    logic [IDX_W-1:0]        bc [LEAVES];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // Expected lane sum from the shadow vector (R1, R4, R8).
    function automatic longint beat_sum();
        longint s = 0;
        for (int i = 0; i < LEAVES; i++) begin
            if (bc[i] < DEPTH) s += longint'(bv[i]) * shadow[bc[i]];
        end
        return s;
    endfunction

    task automatic tick();
        @(negedge clk);
        cyc++;
        chk(in_rd == !in_empty, "R2 in_rd", longint'(in_rd), longint'(!in_empty));
        if (cyc >= LAT) begin
            int k = cyc - LAT;
            logic signed [SUM_W-1:0] xs = es[k][SUM_W-1:0];
            chk(out_valid == ev[k], "R3 out_valid", longint'(out_valid), longint'(ev[k]));
            chk(out_tag == (ev[k] ? et[k] : '0), "R6 out_tag", longint'(out_tag), longint'(ev[k] ? et[k] : '0));
            chk(out_sum == xs, ev[k] ? "R1 out_sum" : "R5 bubble sum", longint'(out_sum), longint'(xs));
        end
    endtask

    task automatic drive_beat(input logic [TAG_W-1:0] tag);
        in_empty = 1'b0;
        vec_we   = 1'b0;
        in_tag   = tag;
        for (int i = 0; i < LEAVES; i++) begin
            in_vals[i*VAL_W +: VAL_W] = bv[i];
            in_cols[i*IDX_W +: IDX_W] = bc[i];
        end
        ev[cyc] = 1'b1;
        es[cyc] = beat_sum();
        et[cyc] = tag;
    endtask

    task automatic drive_gap();
        in_empty = 1'b1;
        vec_we   = 1'b0;
        in_vals  = $urandom();
        in_cols  = $urandom();
        in_tag   = 8'hA5;
    endtask

    task automatic drive_write(input int addr, input logic [VAL_W-1:0] d, input bit takes);
        in_empty = 1'b1;
        vec_we   = 1'b1;
        vec_addr = IDX_W'(addr);
        vec_data = d;
        if (takes && addr < DEPTH) shadow[addr] = longint'($signed(d));
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL R3 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NREC; i++) begin ev[i] = 0; es[i] = 0; et[i] = '0; end
        for (int i = 0; i < DEPTH; i++) shadow[i] = 0;
        rst_n = 1'b0; in_empty = 1'b1; vec_we = 1'b0; vec_addr = '0; vec_data = '0;
        in_vals = '0; in_cols = '0; in_tag = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(out_valid == 1'b0, "R9 reset valid", longint'(out_valid), 0);
        chk(out_sum == '0, "R9 reset sum", longint'(out_sum), 0);
        chk(out_tag == '0, "R9 reset tag", longint'(out_tag), 0);
        rst_n = 1'b1;

        // Load the vector while idle (R7).
        for (int a = 0; a < DEPTH; a++) begin
            tick(); drive_write(a, VAL_W'($urandom()), 1'b1);
        end
        tick(); drive_write(10, 16'h8000, 1'b1);
        tick(); drive_write(11, 16'h8000, 1'b1);
        tick(); drive_write(12, 16'h7FFF, 1'b1);
        tick(); drive_write(13, 16'h8000, 1'b1);
        tick(); drive_write(5, 16'd111, 1'b1);
        tick(); drive_write(5, 16'hFFF3, 1'b1);              // R7: latest write wins
        tick(); drive_write(DEPTH + 6, 16'h1234, 1'b0);      // R7: out-of-range write ignored
        tick(); drive_gap();

        // R1: plain beat
        tick(); bv = '{16'sd1, 16'sd2, 16'sd3, 16'sd4}; bc = '{16'd0, 16'd1, 16'd2, 16'd3}; drive_beat(8'h01);
        // R4: zero padding
        tick(); bv = '{16'sd7, 16'sd0, 16'sd0, 16'sd0}; bc = '{16'd5, 16'd9, 16'd40, 16'd63}; drive_beat(8'h02);
        // R1: extreme operands near the top of the sum width
        tick(); bv = '{-16'sd32768, -16'sd32768, -16'sd32768, 16'sd32767}; bc = '{16'd10, 16'd11, 16'd12, 16'd13}; drive_beat(8'h03);
        tick(); bv = '{-16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768}; bc = '{16'd10, 16'd11, 16'd13, 16'd10}; drive_beat(8'h04);
        // R8: out-of-range column indices
        tick(); bv = '{16'sd5, 16'sd5, 16'sd5, 16'sd5}; bc = '{16'd64, 16'hFFFF, 16'd6, 16'd100}; drive_beat(8'h05);

        // R7, R9: writes during DRAIN are ignored, first IDLE cycle accepts.
        tick(); bv = '{16'sd1, 16'sd1, 16'sd1, 16'sd1}; bc = '{16'd20, 16'd21, 16'd22, 16'd23}; drive_beat(8'h06);
        tick(); drive_write(6, 16'd999, 1'b0);
        for (int g = 2; g < LAT; g++) begin tick(); drive_gap(); end
        tick(); drive_write(7, 16'd777, 1'b0);                // LAT after read: still DRAIN
        tick(); drive_write(8, 16'd555, 1'b1);                // LAT+1 after read: IDLE
        tick(); bv = '{16'sd1, 16'sd1, 16'sd1, 16'sd0}; bc = '{16'd6, 16'd7, 16'd8, 16'd9}; drive_beat(8'h07);
        tick(); bv = '{16'sd3, 16'sd0, 16'sd0, 16'sd0}; bc = '{16'd8, 16'd0, 16'd0, 16'd0}; drive_beat(8'h08);
        tick(); drive_gap();                                  // R5 bubble inside a stream
        tick(); bv = '{16'sd2, 16'sd0, 16'sd0, 16'sd0}; bc = '{16'd6, 16'd0, 16'd0, 16'd0}; drive_beat(8'h09);

        // Random stream with gaps, zero lanes and out-of-range indices.
        for (int r = 0; r < 600; r++) begin
            tick();
            if ($urandom_range(3) == 0) drive_gap();
            else begin
                for (int i = 0; i < LEAVES; i++) begin
                    bv[i] = ($urandom_range(4) == 0) ? '0 : VAL_W'($urandom());
                    bc[i] = IDX_W'($urandom_range(DEPTH + 7));
                end
                drive_beat(TAG_W'($urandom()));
            end
        end

        for (int g = 0; g < LAT + 3; g++) begin tick(); drive_gap(); end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule